// File: doc/BRIEF.md
# Configurable-Length Synchronous Serial Receiver

This block is the receive half of a clocked serial port of the SPI kind. A peer device drives an active-low select, a serial clock and a data line. The clock idles low and each data bit is taken on the rising clock edge. The three line inputs are brought into the system clock domain through two-flop synchronizers. A rising clock edge is recognised by comparing the synchronized clock with its value one cycle earlier.

A frame is 8, 16 or 32 bits long. Each byte on the line arrives either least-significant bit first or most-significant bit first. Received bytes go into a bank of four byte-wide data registers. With MSB-first order, the first byte lands in register 0 and the following bytes go to higher registers. With LSB-first order, the first byte lands in the highest register the frame uses and the last byte lands in register 0. When a whole frame has arrived, the valid registers update together. At the same moment a receive-full flag sets and an interrupt pulse is issued.

Software reads the registers through a simple read port. Before reception it does a dummy read, and after each frame it reads the data. Reading register 0 clears the flag. The frame length and bit order are captured when a frame begins.

A control state machine sequences each frame. Its states are:
- `ST_IDLE`: the select line is high.
- `ST_RECV`: bits are being shifted in.
- `ST_DONE`: a one-cycle commit state.

Its transitions are:
- `IDLE→RECV` when the select line goes low. The settings are captured here.
- `RECV→IDLE` when the select line rises mid-frame. The partial frame is discarded.
- `RECV→DONE` when the last bit of the frame is sampled.
- `DONE→RECV` when the select line is still low. The settings are captured again.
- `DONE→IDLE` when the select line has risen.

Top module: `ssr_rx_top`

## Requirements
- R1: `cfg_len` selects the frame length: 00 is 8 bits, 01 is 16 bits, and 10 or 11 is 32 bits. An 8-bit frame writes only register 0, a 16-bit frame writes registers 0 and 1, and a 32-bit frame writes registers 0 to 3. Registers that the frame does not use keep their values.
- R2: With `cfg_msb_first`=0, bit 0 of each byte is the first bit on the line. With `cfg_msb_first`=1, bit 7 is the first bit on the line.
- R3: In MSB-first order, the k-th byte received (counting from 0) is stored in register k.
- R4: In LSB-first order, the k-th byte received is stored in register (nbytes-1-k). The first byte therefore goes to the highest valid register and the last byte goes to register 0.
- R5: `rx_full` sets once per complete frame, and never after an individual byte of a longer frame.
- R6: `rx_irq` is a single-cycle pulse. It occurs in the same cycle that `rx_full` rises and the data registers take their new values. The data registers change at no other time.
- R7: A read strobe (`rd_en`=1) with `rd_addr`=0 clears `rx_full` on the next cycle. A read of any other address leaves `rx_full` unchanged.
- R8: If a frame completes in the same cycle as a read of register 0, `rx_full` stays set.
- R9: If the select line rises before a frame is complete, the partial frame is discarded. No flag, interrupt or register update results, and the next frame starts again from bit 0.
- R10: The frame length and bit order are sampled at the start of each frame. Changes to them during a frame do not affect that frame.
- R11: After reset, `rx_full` and `rx_irq` are 0 and all data registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Serial select, active low (asynchronous to clk) |
| sclk | input | 1 | Serial clock, idle low, data taken on rising edge |
| sdata | input | 1 | Serial data in |
| cfg_len | input | 2 | Frame length code (see R1) |
| cfg_msb_first | input | 1 | 1: MSB-first bit order, 0: LSB-first |
| rd_en | input | 1 | Read strobe; a read of address 0 clears the flag |
| rd_addr | input | 2 | Data register index |
| rd_data | output | 8 | Contents of the addressed data register |
| rx_full | output | 1 | Receive-full flag |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The checker watches the flag and interrupt handshake on every cycle:
- the flag can rise only together with the interrupt;
- the interrupt lasts a single cycle and never occurs without the flag;
- the flag can fall only after a read of register 0;
- the addressed register changes only in an interrupt cycle.

Some behaviours can only be shown by the bench's scenarios:
- the byte-to-register mapping for each length and bit order;
- the discarding of a frame cut short by the select line;
- the holding of the settings across a mid-frame change;
- the set-over-clear priority when a frame ends during a read.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 4;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int BIT_W    = $clog2(BYTE_W);
    localparam int CNT_W    = IDX_W + BIT_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DONE = 2'd2
    } rx_state_e;

    // Index of the highest data register a frame of the given length uses.
    function automatic logic [IDX_W-1:0] last_byte_idx(input logic [1:0] len_code);
        logic [IDX_W-1:0] r;
        unique case (len_code)
            2'd0:    r = IDX_W'(0);
            2'd1:    r = IDX_W'(1);
            default: r = IDX_W'(NUM_REGS - 1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
    parameter int              WIDTH     = 1,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {STAGES{RESET_VAL}};
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
    import ssr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_s,
    input  logic             sclk_rise,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_msb_first,
    output logic             shift_en,
    output logic             byte_wr,
    output logic [IDX_W-1:0] wr_idx,
    output logic             frame_done,
    output logic             msb_first,
    output logic [IDX_W-1:0] last_idx
);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] last_q;
    logic             msb_q;
    logic             start;
    logic             last_bit;
    logic [IDX_W-1:0] byte_idx;

    // Frame start: select low while not shifting.
    assign start = (state_q != ST_RECV) && !cs_n_s;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!cs_n_s) state_d = ST_RECV;
            ST_RECV: begin
                if (cs_n_s)                     state_d = ST_IDLE;
                else if (shift_en && last_bit)  state_d = ST_DONE;
            end
            ST_DONE: state_d = cs_n_s ? ST_IDLE : ST_RECV;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit counter and per-frame settings.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
            msb_q  <= 1'b0;
        end else if (start) begin
            cnt_q  <= '0;
            last_q <= last_byte_idx(cfg_len);
            msb_q  <= cfg_msb_first;
        end else if (shift_en) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        shift_en   = (state_q == ST_RECV) && !cs_n_s && sclk_rise;
        last_bit   = (cnt_q == {last_q, {BIT_W{1'b1}}});
        byte_wr    = shift_en && (&cnt_q[BIT_W-1:0]);
        byte_idx   = cnt_q[CNT_W-1:BIT_W];
        wr_idx     = msb_q ? byte_idx : (last_q - byte_idx);
        frame_done = (state_q == ST_DONE);
        msb_first  = msb_q;
        last_idx   = last_q;
    end

endmodule

// File: rtl/ssr_regbank.sv
module ssr_regbank
    import ssr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              msb_first,
    input  logic              byte_wr,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              frame_done,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rx_full,
    output logic              rx_irq
);

    logic [BYTE_W-1:0] byte_sr;
    logic [BYTE_W-1:0] next_byte;
    logic [BYTE_W-1:0] stage [NUM_REGS];
    logic [BYTE_W-1:0] data  [NUM_REGS];

    always_comb begin
        if (msb_first) next_byte = {byte_sr[BYTE_W-2:0], bit_in};
        else           next_byte = {bit_in, byte_sr[BYTE_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        byte_sr <= '0;
        else if (shift_en) byte_sr <= next_byte;
    end

    // Staging holds the frame under assembly; data commits on frame end.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                stage[i] <= '0;
                data[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (byte_wr && (wr_idx == IDX_W'(i)))
                    stage[i] <= next_byte;
                if (frame_done && (IDX_W'(i) <= last_idx))
                    data[i] <= stage[i];
            end
        end
    end

    // Flag: set has priority over the clear caused by a read of register 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            rx_irq  <= 1'b0;
        end else begin
            rx_irq <= frame_done;
            if (frame_done)
                rx_full <= 1'b1;
            else if (rd_en && (rd_addr == '0))
                rx_full <= 1'b0;
        end
    end

    assign rd_data = data[rd_addr];

endmodule

// File: rtl/ssr_rx_top.sv
module ssr_rx_top
    import ssr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdata,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_msb_first,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rx_full,
    output logic              rx_irq
);

    logic [2:0]       line_s;
    logic             cs_n_s, sclk_s, sdata_s;
    logic             sclk_d;
    logic             sclk_rise;
    logic             shift_en, byte_wr, frame_done, msb_first;
    logic [IDX_W-1:0] wr_idx, last_idx;

    ssr_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs_n, sclk, sdata}),
        .q    (line_s)
    );

    assign {cs_n_s, sclk_s, sdata_s} = line_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign sclk_rise = sclk_s && !sclk_d;

    ssr_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_s       (cs_n_s),
        .sclk_rise    (sclk_rise),
        .cfg_len      (cfg_len),
        .cfg_msb_first(cfg_msb_first),
        .shift_en     (shift_en),
        .byte_wr      (byte_wr),
        .wr_idx       (wr_idx),
        .frame_done   (frame_done),
        .msb_first    (msb_first),
        .last_idx     (last_idx)
    );

    ssr_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .bit_in    (sdata_s),
        .msb_first (msb_first),
        .byte_wr   (byte_wr),
        .wr_idx    (wr_idx),
        .frame_done(frame_done),
        .last_idx  (last_idx),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rx_full   (rx_full),
        .rx_irq    (rx_irq)
    );

endmodule

// File: rtl/ssr_rx_checker.sv
module ssr_rx_checker
    import ssr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [IDX_W-1:0]  rd_addr,
    input logic [BYTE_W-1:0] rd_data,
    input logic              rx_full,
    input logic              rx_irq
);

    assert_flag_rise_with_irq_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> rx_irq
    );

    assert_irq_implies_flag_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full
    );

    assert_irq_single_pulse_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq
    );

    assert_clear_needs_read_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(rd_en && (rd_addr == '0))
    );

    assert_data_only_on_irq_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!rx_irq && (rd_addr == $past(rd_addr))) |-> $stable(rd_data)
    );

endmodule

bind ssr_rx_top ssr_rx_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .rx_full(rx_full),
    .rx_irq (rx_irq)
);

// File: tb/ssr_rx_top_test.sv
module ssr_rx_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdata = 1'b0;
    logic [1:0] cfg_len = 2'd0;
    logic       cfg_msb_first = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       rx_full;
    logic       rx_irq;

    int checks = 0;
    int fails = 0;
    int irq_seen = 0;
    bit finished = 0;
    logic [7:0] model [4] = '{8'h00, 8'h00, 8'h00, 8'h00};

    always #2 clk = ~clk;

    ssr_rx_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .sdata        (sdata),
        .cfg_len      (cfg_len),
        .cfg_msb_first(cfg_msb_first),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .rx_full      (rx_full),
        .rx_irq       (rx_irq)
    );

    always @(negedge clk) if (rst_n && rx_irq) irq_seen++;

    // {length code, msb_first, bytes in line order: byte k at [8k+:8]}
    localparam logic [34:0] VEC [7] = '{
        {2'd0, 1'b1, 32'h0000_003C},
        {2'd0, 1'b0, 32'h0000_00A1},
        {2'd1, 1'b1, 32'h0000_5AC3},
        {2'd1, 1'b0, 32'h0000_12F0},
        {2'd2, 1'b1, 32'hDEAD_BEEF},
        {2'd2, 1'b0, 32'h0102_8040},
        {2'd3, 1'b0, 32'h7E81_C3A5}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int nbytes_of(input logic [1:0] len);
        return (len == 2'd0) ? 1 : (len == 2'd1) ? 2 : 4;
    endfunction

    task automatic apply_model(input logic [1:0] len, input bit msb, input logic [31:0] d);
        int nb = nbytes_of(len);
        for (int k = 0; k < nb; k++) begin
            int idx = msb ? k : (nb - 1 - k);
            model[idx] = d[8*k +: 8];
        end
    endtask

    task automatic read_pulse(input logic [1:0] addr);
        rd_addr = addr; rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
    endtask

    task automatic start_frame(input logic [1:0] len, input bit msb);
        cfg_len = len; cfg_msb_first = msb;
        tick(2);
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic end_frame;
        sclk = 1'b0;
        tick(4);
        cs_n = 1'b1;
        tick(8);
    endtask

    // Sends line bits first..first+count-1; leaves sclk high after the last one.
    task automatic send_bits(input logic [31:0] d, input bit msb, input int first, input int count);
        for (int t = first; t < first + count; t++) begin
            int k = t / 8;
            int j = t % 8;
            sdata = msb ? d[8*k + 7 - j] : d[8*k + j];
            sclk = 1'b0;
            tick(4);
            sclk = 1'b1;
            if (t != first + count - 1) tick(4);
        end
    endtask

    task automatic wait_irq(output bit got);
        got = 0;
        for (int i = 0; i < 64; i++) begin
            tick(1);
            if (rx_irq) begin
                got = 1;
                break;
            end
        end
    endtask

    task automatic check_regs(input string tag);
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            tick(1);
            chk(tag, {24'h0, rd_data}, {24'h0, model[a]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit got;
        int base;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R11: reset state
        chk("R11 flag", {31'h0, rx_full}, 0);
        chk("R11 irq", {31'h0, rx_irq}, 0);
        check_regs("R11 regs");

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 7; v++) begin
            logic [1:0]  len = VEC[v][34:33];
            bit          msb = VEC[v][32];
            logic [31:0] d   = VEC[v][31:0];
            read_pulse(2'd0);               // dummy read
            start_frame(len, msb);
            base = irq_seen;
            send_bits(d, msb, 0, nbytes_of(len) * 8);
            wait_irq(got);
            chk("R6 flag with irq", {31'h0, rx_full}, {31'h0, got});
            apply_model(len, msb, d);
            end_frame();
            chk("R5 one flag per frame", irq_seen - base, 1);
            check_regs(msb ? "R1 R2 R3 regs" : "R1 R2 R4 regs");
            read_pulse(2'd1);
            chk("R7 other read keeps flag", {31'h0, rx_full}, 1);
            read_pulse(2'd0);
            chk("R7 read0 clears flag", {31'h0, rx_full}, 0);
        end

        // R9: aborted partial frame
        base = irq_seen;
        start_frame(2'd0, 1'b0);
        send_bits(32'h0000_00FF, 1'b0, 0, 5);
        tick(4);
        end_frame();
        chk("R9 no irq on abort", irq_seen - base, 0);
        chk("R9 no flag on abort", {31'h0, rx_full}, 0);
        check_regs("R9 regs untouched");
        start_frame(2'd0, 1'b0);
        send_bits(32'h0000_0096, 1'b0, 0, 8);
        wait_irq(got);
        end_frame();
        apply_model(2'd0, 1'b0, 32'h0000_0096);
        chk("R9 restart count", irq_seen - base, 1);
        check_regs("R9 fresh frame");
        read_pulse(2'd0);

        // R10: settings changed mid-frame are ignored
        base = irq_seen;
        start_frame(2'd2, 1'b1);
        send_bits(32'hC0FF_EE11, 1'b1, 0, 8);
        tick(4);
        cfg_len = 2'd0; cfg_msb_first = 1'b0;
        send_bits(32'hC0FF_EE11, 1'b1, 8, 24);
        wait_irq(got);
        end_frame();
        apply_model(2'd2, 1'b1, 32'hC0FF_EE11);
        chk("R10 single frame", irq_seen - base, 1);
        check_regs("R10 held settings");
        read_pulse(2'd0);

        // R8: frame completes while register 0 is being read
        rd_addr = 2'd0; rd_en = 1'b1;
        start_frame(2'd1, 1'b1);
        send_bits(32'h0000_3344, 1'b1, 0, 16);
        wait_irq(got);
        chk("R8 irq seen", {31'h0, got}, 1);
        chk("R8 set wins over clear", {31'h0, rx_full}, 1);
        tick(1);
        chk("R7 held read clears", {31'h0, rx_full}, 0);
        rd_en = 1'b0;
        end_frame();
        apply_model(2'd1, 1'b1, 32'h0000_3344);
        check_regs("R3 after collision");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule